// File: doc/BRIEF.md
# Almost-Flag Threshold Register Sequencer

This block keeps the two thresholds that drive a FIFO's almost-empty and almost-full flags. Each threshold is split into a low byte and a short high part. The high part has AW-8 bits, where AW is the FIFO address width. Software or a host port writes the thresholds one word at a time through the FIFO's own write data bus, and reads them back through its read data bus.

There is no address. A shared active-low load strobe selects threshold access instead of normal FIFO traffic. A two-bit slot pointer on each side walks through the four registers in a fixed cyclic order:

1. empty low byte
2. empty high part
3. full low byte
4. full high part

Each pointer keeps its place when load is released, so a partial sequence continues where it stopped. Only reset returns the pointers to the first slot.

The read side delivers its words as a stream. `rdata_vld` marks each word. There is no back-pressure: one word appears per read-clock cycle in which load and read enable are both low. The caller must take the word in that cycle.

The full thresholds appear on `empty_off` and `full_off` for the flag logic, which is not part of this block. During a load cycle, the block withholds the normal FIFO write and read strobes.

Top module: `offs_load_seq`

## Requirements
- R1: After reset, `empty_off` and `full_off` both equal 7, `rdata` is 0 and `rdata_vld` is 0.
- R2: Each write-clock edge with `ld_n`=0 and `wen_n`=0 writes the current slot and advances the write pointer. The slots are taken in order: empty low byte (wdata[7:0] into empty_off[7:0]), empty high part (wdata[AW-9:0] into empty_off[AW-1:8]), full low byte, full high part.
- R3: The fifth consecutive load write wraps to the empty low byte.
- R4: A write-clock edge with `ld_n`=1 or `wen_n`=1 changes neither threshold nor the write pointer.
- R5: After a load is released, the next load write goes to the slot after the last one written, not to the first slot.
- R6: Each read-clock edge with `ld_n`=0 and `ren_n`=0 places the current slot's value on `rdata`, raises `rdata_vld` in the following cycle, and advances the read pointer in the same four-slot order, wrapping after the fourth slot.
- R7: Data bits above a register's width are ignored on write, and they read back as zero. This covers bit 8 for the low-byte slots and bits 8..AW-8 for the high-part slots.
- R8: `fifo_wr_en` is high exactly when `wen_n`=0 and `ld_n`=1, and `fifo_rd_en` is high exactly when `ren_n`=0 and `ld_n`=1.
- R9: A read-clock edge without a readback leaves `rdata` unchanged and drives `rdata_vld` low.
- R10: The read pointer advances independently of the write pointer. Reset returns both pointers to the empty low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, both sides |
| ld_n | input | 1 | Active-low threshold access strobe |
| wen_n | input | 1 | Active-low write enable |
| wdata | input | 9 | Write data bus |
| ren_n | input | 1 | Active-low read enable |
| rdata | output | 9 | Readback word |
| rdata_vld | output | 1 | Readback word valid |
| fifo_wr_en | output | 1 | Normal FIFO write strobe, withheld during load |
| fifo_rd_en | output | 1 | Normal FIFO read strobe, withheld during load |
| empty_off | output | AW | Almost-empty threshold |
| full_off | output | AW | Almost-full threshold |

## Verification
The strobes `fifo_wr_en` and `fifo_rd_en` are combinational. The bench checks them about 1 ns after it drives the inputs, before the next clock edge.

A threshold update shows on `empty_off` or `full_off` after the one write-clock edge that performs the load. The bench therefore samples 1 ns after that edge.

A readback word and its `rdata_vld` are registered once on the read clock. They are checked 1 ns after the capturing read edge, and the hold case is checked one edge later. All inputs change on falling edges, so no check depends on the order of processes at a rising edge.

// File: rtl/offs_pkg.sv
package offs_pkg;
  localparam int LSB_W = 8;
  localparam int BUS_W = 9;
  localparam logic [LSB_W-1:0] LSB_RST = 8'h07;

  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_e;
endpackage

// File: rtl/offs_seq_ptr.sv
module offs_seq_ptr (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output offs_pkg::slot_e     slot
);
  import offs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= SLOT_E_LO;
    else if (step) slot <= slot_e'(slot + 2'd1);
  end
endmodule

// File: rtl/offs_regfile.sv
module offs_regfile #(
  parameter int HI_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  offs_pkg::slot_e               slot,
  input  logic [offs_pkg::BUS_W-1:0]    wdata,
  output logic [offs_pkg::LSB_W-1:0]    lo_q [2],
  output logic [HI_W-1:0]               hi_q [2]
);
  import offs_pkg::*;

  // index 0 = empty threshold, index 1 = full threshold
  for (genvar k = 0; k < 2; k++) begin : g_thr
    wire sel = we && (slot[1] == 1'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[k] <= LSB_RST;
        hi_q[k] <= '0;
      end else if (sel) begin
        if (!slot[0]) lo_q[k] <= wdata[LSB_W-1:0];
        else          hi_q[k] <= wdata[HI_W-1:0];
      end
    end
  end
endmodule

// File: rtl/offs_readback.sv
module offs_readback #(
  parameter int HI_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  offs_pkg::slot_e               slot,
  input  logic [offs_pkg::LSB_W-1:0]    lo_q [2],
  input  logic [HI_W-1:0]               hi_q [2],
  output logic [offs_pkg::BUS_W-1:0]    rdata,
  output logic                          rdata_vld
);
  import offs_pkg::*;

  logic [BUS_W-1:0] word;

  always_comb begin
    word = '0;
    if (!slot[0]) word[LSB_W-1:0] = lo_q[slot[1]];
    else          word[HI_W-1:0]  = hi_q[slot[1]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= step;
      if (step) rdata <= word;
    end
  end
endmodule

// File: rtl/offs_load_seq.sv
module offs_load_seq #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int HI_W = AW - offs_pkg::LSB_W
) (
  input  logic                       wr_clk,
  input  logic                       rd_clk,
  input  logic                       rst_n,
  input  logic                       ld_n,
  input  logic                       wen_n,
  input  logic [offs_pkg::BUS_W-1:0] wdata,
  input  logic                       ren_n,
  output logic [offs_pkg::BUS_W-1:0] rdata,
  output logic                       rdata_vld,
  output logic                       fifo_wr_en,
  output logic                       fifo_rd_en,
  output logic [AW-1:0]              empty_off,
  output logic [AW-1:0]              full_off
);
  import offs_pkg::*;

  logic wr_step, rd_step;
  slot_e wr_slot, rd_slot;
  logic [LSB_W-1:0] lo_q [2];
  logic [HI_W-1:0]  hi_q [2];

  assign wr_step    = !ld_n && !wen_n;
  assign rd_step    = !ld_n && !ren_n;
  assign fifo_wr_en = ld_n && !wen_n;
  assign fifo_rd_en = ld_n && !ren_n;

  offs_seq_ptr wr_ptr_i (.clk(wr_clk), .rst_n(rst_n), .step(wr_step), .slot(wr_slot));
  offs_seq_ptr rd_ptr_i (.clk(rd_clk), .rst_n(rst_n), .step(rd_step), .slot(rd_slot));

  offs_regfile #(.HI_W(HI_W)) regs_i (
    .clk(wr_clk), .rst_n(rst_n), .we(wr_step), .slot(wr_slot),
    .wdata(wdata), .lo_q(lo_q), .hi_q(hi_q)
  );

  // Thresholds are quasi-static: the read side samples them only while load is held.
  offs_readback #(.HI_W(HI_W)) rb_i (
    .clk(rd_clk), .rst_n(rst_n), .step(rd_step), .slot(rd_slot),
    .lo_q(lo_q), .hi_q(hi_q), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  assign empty_off = {hi_q[0], lo_q[0]};
  assign full_off  = {hi_q[1], lo_q[1]};
endmodule

// File: rtl/offs_load_seq_chk.sv
module offs_load_seq_chk #(
  parameter int AW = 10
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          ld_n,
  input logic          wen_n,
  input logic          ren_n,
  input logic          fifo_wr_en,
  input logic [AW-1:0] empty_off,
  input logic [AW-1:0] full_off,
  input logic [8:0]    rdata,
  input logic          rdata_vld,
  input logic [1:0]    wr_slot,
  input logic [1:0]    rd_slot
);
  // R2
  wr_advance_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!ld_n && !wen_n) |=> (wr_slot == 2'($past(wr_slot) + 2'd1)));

  // R4
  no_stray_write_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !(!ld_n && !wen_n) |=> ($stable(empty_off) && $stable(full_off) && $stable(wr_slot)));

  // R8
  fifo_wr_no_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    fifo_wr_en |=> $stable(wr_slot));

  // R6
  rb_valid_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!ld_n && !ren_n) |=> (rdata_vld && rd_slot == 2'($past(rd_slot) + 2'd1)));

  // R9
  rb_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(!ld_n && !ren_n) |=> (!rdata_vld && $stable(rdata) && $stable(rd_slot)));

  // R7
  rb_top_bit_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rdata_vld |-> !rdata[8]);
endmodule

bind offs_load_seq offs_load_seq_chk #(.AW(AW)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n),
  .wen_n(wen_n), .ren_n(ren_n), .fifo_wr_en(fifo_wr_en),
  .empty_off(empty_off), .full_off(full_off), .rdata(rdata),
  .rdata_vld(rdata_vld), .wr_slot(wr_slot), .rd_slot(rd_slot)
);

// File: tb/offs_load_seq_tb.sv
`timescale 1ns/1ps
module offs_load_seq_tb_top;
  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic ld_n = 1, wen_n = 1, ren_n = 1;
  logic [8:0] wdata = '0;
  logic [8:0] rdata;
  logic rdata_vld, fifo_wr_en, fifo_rd_en;
  logic [9:0] empty_off, full_off;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 wr_clk = ~wr_clk;
  initial begin #1.25; forever #2.5 rd_clk = ~rd_clk; end

  offs_load_seq dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n),
    .wen_n(wen_n), .wdata(wdata), .ren_n(ren_n), .rdata(rdata),
    .rdata_vld(rdata_vld), .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en),
    .empty_off(empty_off), .full_off(full_off)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {ld_n, wen_n, wdata[8:0], expected empty_off[9:0], expected full_off[9:0]}
  localparam logic [30:0] VEC [9] = '{
    {1'b0, 1'b0, 9'h1A5, 10'h0A5, 10'h007},  // R2 empty low byte, R7 bit 8 dropped
    {1'b0, 1'b1, 9'h1FF, 10'h0A5, 10'h007},  // R4 wen high
    {1'b1, 1'b0, 9'h0FF, 10'h0A5, 10'h007},  // R4 normal write, R8
    {1'b0, 1'b0, 9'h1FE, 10'h2A5, 10'h007},  // R2 empty high part, R7
    {1'b0, 1'b0, 9'h033, 10'h2A5, 10'h033},  // R2 full low byte
    {1'b0, 1'b0, 9'h1FD, 10'h2A5, 10'h133},  // R2 full high part
    {1'b0, 1'b0, 9'h011, 10'h211, 10'h133},  // R3 wrap
    {1'b1, 1'b0, 9'h000, 10'h211, 10'h133},  // R5 release
    {1'b0, 1'b0, 9'h001, 10'h111, 10'h133}   // R5 resume at high part
  };
  localparam logic [8:0] RB_EXP [5] = '{9'h011, 9'h001, 9'h033, 9'h001, 9'h011};

  initial begin
    #12 rst_n = 1;
    #0.5;
    // R1 reset state
    check("R1 empty_off", empty_off, 10'h007);
    check("R1 full_off", full_off, 10'h007);
    check("R1 rdata", rdata, 0);
    check("R1 rdata_vld", rdata_vld, 0);

    for (int i = 0; i < 9; i++) begin
      @(negedge wr_clk);
      {ld_n, wen_n, wdata} = VEC[i][30:20];
      #1;
      check("R8 fifo_wr_en", fifo_wr_en, int'(ld_n && !wen_n));
      @(posedge wr_clk); #1;
      check("R2/R3/R4/R5 empty_off", empty_off, VEC[i][19:10]);
      check("R2/R3/R4/R5 full_off", full_off, VEC[i][9:0]);
    end
    @(negedge wr_clk); wen_n = 1; ld_n = 1;

    // R6 readback order and wrap; R10 read pointer starts at slot 0 regardless of write pointer
    for (int i = 0; i < 5; i++) begin
      @(negedge rd_clk); ld_n = 0; ren_n = 0;
      #0.5 check("R8 fifo_rd_en", fifo_rd_en, 0);
      @(posedge rd_clk); #1;
      check("R6 R7 R10 rdata", rdata, RB_EXP[i]);
      check("R6 rdata_vld", rdata_vld, 1);
    end
    // R9 hold without readback
    @(negedge rd_clk); ren_n = 1;
    @(posedge rd_clk); #1;
    check("R9 rdata hold", rdata, 9'h011);
    check("R9 rdata_vld low", rdata_vld, 0);
    @(negedge rd_clk); ld_n = 1; ren_n = 0;
    #0.5 check("R8 fifo_rd_en", fifo_rd_en, 1);
    @(posedge rd_clk); #1;
    check("R9 no readback in normal read", rdata_vld, 0);
    check("R9 rdata kept", rdata, 9'h011);
    @(negedge rd_clk); ren_n = 1;

    // R10 reset returns pointers and defaults
    rst_n = 0; #3; rst_n = 1;
    check("R1 empty_off after reset", empty_off, 10'h007);
    @(negedge rd_clk); ld_n = 0; ren_n = 0;
    @(posedge rd_clk); #1;
    check("R10 read pointer at slot 0", rdata, 9'h007);
    @(negedge rd_clk); ld_n = 1; ren_n = 1;
    @(negedge wr_clk); ld_n = 0; wen_n = 0; wdata = 9'h05A;
    @(posedge wr_clk); #1;
    check("R10 write pointer at slot 0", empty_off, 10'h05A);
    @(negedge wr_clk); ld_n = 1; wen_n = 1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule